// File: doc/BRIEF.md
# Packed-Syllable Instruction Fetch Sequencer

This block is the front end of a small stack processor. It reads 32-bit instruction words from an instruction memory, sorts each word into one of three formats by its two top bits, and passes the work it finds to a downstream execution unit over a valid/ready handshake. A word with bit 31 set becomes one wide-immediate push. A word whose top two bits are `00` carries five 6-bit syllables, which are handed out one per accepted transfer. A word whose top two bits are `01` is reserved and yields nothing.

The sequencer keeps the program counter and a syllable counter that both point at the next thing to run. While a syllable of a word is on the output, the program counter already holds that word's address plus 4. The execution unit sends jumps and taken branches back as a redirect, which throws away whatever is left of the current word and restarts fetch at the target. A halt syllable stops the sequencer for good until reset.

The instruction memory is synchronous with a fixed latency of one cycle: read data for a request is expected in the cycle after `imem_req` is high.

Top module: `syl_fetch_seq`

## Requirements
- R1: Reset: after synchronous reset (`rst_n` low) `halted` and `out_valid` are 0, and in the first cycle after release `imem_req` is 1 with `imem_addr` equal to `RESET_PC`.
- R2: Memory timing: `imem_rdata` is sampled in the cycle after a cycle with `imem_req` high; each word takes one request cycle and one capture cycle before its first output.
- R3: A word with bit 31 = 1 produces exactly one item with `out_kind` = 1, `out_imm` = word shifted left by one with bit 0 = 0 (word 0xC0404040 gives 0x80808080), `out_syl` = 0 and `sc_o` = 0.
- R4: A word with bits 31:30 = `01` produces no item; the next fetch is at its address plus 4.
- R5: A word with bits 31:30 = `00` produces five items with `out_kind` = 0, in the order bits 29:24, 23:18, 17:12, 11:6, 5:0.
- R6: While the syllable at position k (0 to 4) of the word at address A is on the output, `pc_o` = A + 4 and `sc_o` = (k + 1) mod 5; for the middle syllable of the word at 0x200 this is 0x204 and 3.
- R7: While `out_valid` is 1 and `out_ready` is 0 (and no redirect), the item and `pc_o`/`sc_o` hold; the sequencer advances only on a cycle with both high.
- R8: A redirect (`redir_valid` high for a cycle, not halted) discards the rest of the current word, even an item accepted in the same cycle; in the next cycle `out_valid` = 0, `sc_o` = 0 and `imem_req` = 1 with `imem_addr` = target with bits 1:0 cleared.
- R9: Syllable `000000` is presented like any syllable; once it is accepted `halted` goes to 1 and stays there, with `imem_req` and `out_valid` held at 0 and redirects ignored, until reset.
- R10: Syllable `000001` (no-operation) and every other nonzero code pass through as ordinary items without changing fetch.
- R11: After the last item of a word is accepted, the next fetch is at the word's address plus 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 32 | Instruction read address |
| imem_rdata | input | 32 | Read data, valid the cycle after a request |
| out_valid | output | 1 | An item is presented |
| out_ready | input | 1 | Execution unit takes the item |
| out_kind | output | 1 | 1 = wide immediate, 0 = syllable |
| out_syl | output | 6 | Syllable code (0 for an immediate) |
| out_imm | output | 32 | Immediate value (0 for a syllable) |
| pc_o | output | 32 | Program counter |
| sc_o | output | 3 | Syllable counter, 0 to 4 |
| redir_valid | input | 1 | Jump or taken branch |
| redir_target | input | 32 | Redirect target address |
| halted | output | 1 | Halt syllable has been accepted |

## Verification
A wrong syllable index shows at once as a wrong `out_syl` or `sc_o` on the item presented, and a wrong counter step shows as a wrong `pc_o` on the first item of the next word, two cycles after the last item of the previous one was taken. A format mistake shows as a missing or extra item in the accepted stream within one item's time. The bench therefore logs every accepted item with its `pc_o` and `sc_o` and compares the stream with one computed by walking the memory image, under several ready patterns, so any state fault turns into a mismatch in the first item it touches.

// File: rtl/syl_fetch_pkg.sv
package syl_fetch_pkg;

  localparam int WORD_W  = 32;
  localparam int SYL_W   = 6;
  localparam int NUM_SYL = 5;
  localparam int IDX_W   = $clog2(NUM_SYL);

  localparam logic [SYL_W-1:0] HALT_CODE = '0;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_LATCH = 2'd1,
    ST_ISSUE = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    FMT_SYL  = 2'd0,
    FMT_RSVD = 2'd1,
    FMT_WIDE = 2'd2
  } word_fmt_t;

  // Top two bits pick the format: 1x wide, 01 reserved, 00 packed.
  function automatic word_fmt_t word_format(input logic [WORD_W-1:0] w);
    if (w[WORD_W-1])      return FMT_WIDE;
    else if (w[WORD_W-2]) return FMT_RSVD;
    else                  return FMT_SYL;
  endfunction

  // Slot 0 is the most significant syllable under the format bits.
  function automatic logic [SYL_W-1:0] syl_slot(input logic [WORD_W-1:0] w,
                                                input logic [IDX_W-1:0]  idx);
    logic [WORD_W-1:0] sh;
    sh = w >> (SYL_W * (NUM_SYL - 1 - int'(idx)));
    return sh[SYL_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] wide_value(input logic [WORD_W-1:0] w);
    return {w[WORD_W-2:0], 1'b0};
  endfunction

  // Counter that points at the following syllable, wrapping after the last.
  function automatic logic [IDX_W-1:0] sc_after(input logic [IDX_W-1:0] idx);
    if (idx == IDX_W'(NUM_SYL - 1)) return '0;
    else                            return idx + 1'b1;
  endfunction

endpackage

// File: rtl/syl_word_decode.sv
module syl_word_decode
  import syl_fetch_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output word_fmt_t         fmt,
  output logic [SYL_W-1:0]  syl,
  output logic [WORD_W-1:0] imm,
  output logic              is_halt,
  output logic              is_last
);

  always_comb begin
    fmt     = word_format(word);
    syl     = (fmt == FMT_SYL) ? syl_slot(word, idx) : '0;
    imm     = (fmt == FMT_WIDE) ? wide_value(word) : '0;
    is_halt = (fmt == FMT_SYL) && (syl == HALT_CODE);
    is_last = (idx == IDX_W'(NUM_SYL - 1));
  end

endmodule

// File: rtl/syl_pc_unit.sv
module syl_pc_unit #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] target,
  input  logic              step,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= RESET_PC & ALIGN_MASK;
    else if (load) pc_q <= target & ALIGN_MASK;
    else if (step) pc_q <= pc_q + WORD_BYTES;
  end

  assign pc = pc_q;

  // R11: a capture without redirect moves the counter by one word
  p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> pc == $past(pc) + WORD_BYTES);

  // R8: the counter stays word aligned whatever target arrives
  p_pc_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pc[1:0] == 2'b00);

endmodule

// File: rtl/syl_seq_ctrl.sv
module syl_seq_ctrl
  import syl_fetch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  word_fmt_t       fetch_fmt,
  input  word_fmt_t       cur_fmt,
  input  logic            cur_halt,
  input  logic            cur_last,
  input  logic            out_ready,
  input  logic            redir_valid,
  output seq_state_t      state,
  output logic [IDX_W-1:0] idx,
  output logic            ev_fetch,
  output logic            ev_capture,
  output logic            ev_redirect,
  output logic            ev_accept
);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ev_word_done;

  assign ev_fetch     = (state_q == ST_FETCH);
  assign ev_redirect  = redir_valid && (state_q != ST_HALT);
  assign ev_capture   = (state_q == ST_LATCH) && !ev_redirect;
  assign ev_accept    = (state_q == ST_ISSUE) && out_ready;
  assign ev_word_done = ev_accept && ((cur_fmt == FMT_WIDE) || cur_last);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (ev_redirect) begin
      state_d = ST_FETCH;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_FETCH: state_d = ST_LATCH;
        ST_LATCH: begin
          idx_d   = '0;
          state_d = (fetch_fmt == FMT_RSVD) ? ST_FETCH : ST_ISSUE;
        end
        ST_ISSUE: begin
          if (ev_accept) begin
            if (cur_halt)          state_d = ST_HALT;
            else if (ev_word_done) state_d = ST_FETCH;
            else                   idx_d   = idx_q + 1'b1;
          end
        end
        ST_HALT: state_d = ST_HALT;
        default: state_d = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state = state_q;
  assign idx   = idx_q;

  // R4: a reserved word goes straight back to fetch
  p_rsvd_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture && (fetch_fmt == FMT_RSVD) |=> state == ST_FETCH);

  // R2: every capture cycle follows a request cycle
  p_capture_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch && !ev_redirect |=> state == ST_LATCH);

  // R9: halt is terminal
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT);

endmodule

// File: rtl/syl_fetch_seq.sv
module syl_fetch_seq
  import syl_fetch_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [SYL_W-1:0]  out_syl,
  output logic [WORD_W-1:0] out_imm,
  output logic [ADDR_W-1:0] pc_o,
  output logic [IDX_W-1:0]  sc_o,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_target,
  output logic              halted
);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic              ev_fetch, ev_capture, ev_redirect, ev_accept;
  logic [WORD_W-1:0] word_q;
  word_fmt_t         fetch_fmt, cur_fmt;
  logic [SYL_W-1:0]  cur_syl;
  logic [WORD_W-1:0] cur_imm;
  logic              cur_halt, cur_last;
  logic [ADDR_W-1:0] pc;

  assign fetch_fmt = word_format(imem_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n)          word_q <= '0;
    else if (ev_capture) word_q <= imem_rdata;
  end

  syl_word_decode u_decode (
    .word    (word_q),
    .idx     (idx),
    .fmt     (cur_fmt),
    .syl     (cur_syl),
    .imm     (cur_imm),
    .is_halt (cur_halt),
    .is_last (cur_last)
  );

  syl_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_fmt   (fetch_fmt),
    .cur_fmt     (cur_fmt),
    .cur_halt    (cur_halt),
    .cur_last    (cur_last),
    .out_ready   (out_ready),
    .redir_valid (redir_valid),
    .state       (state),
    .idx         (idx),
    .ev_fetch    (ev_fetch),
    .ev_capture  (ev_capture),
    .ev_redirect (ev_redirect),
    .ev_accept   (ev_accept)
  );

  syl_pc_unit #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_redirect),
    .target (redir_target),
    .step   (ev_capture),
    .pc     (pc)
  );

  logic issuing;
  assign issuing = (state == ST_ISSUE);

  assign imem_req  = ev_fetch;
  assign imem_addr = pc;
  assign out_valid = issuing;
  assign out_kind  = issuing && (cur_fmt == FMT_WIDE);
  assign out_syl   = issuing ? cur_syl : '0;
  assign out_imm   = issuing ? cur_imm : '0;
  assign pc_o      = pc;
  assign sc_o      = (issuing && cur_fmt == FMT_SYL) ? sc_after(idx) : '0;
  assign halted    = (state == ST_HALT);

  // R7: a stalled item holds still
  p_hold_item_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !redir_valid |=>
      out_valid && $stable(out_kind) && $stable(out_syl) && $stable(out_imm)
      && $stable(pc_o) && $stable(sc_o));

  // R8: a redirect flushes and refetches at the aligned target
  p_redirect_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && !halted |=>
      imem_req && !out_valid && sc_o == '0
      && imem_addr == ($past(redir_target) & ~ADDR_W'(3)));

  // R9: nothing leaves a halted sequencer
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_req && !out_valid);

  // R3: an immediate item carries no syllable and no counter
  p_wide_item_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind |-> sc_o == '0 && out_syl == '0 && out_imm[0] == 1'b0);

endmodule

// File: tb/tb_syl_fetch_seq.sv
`timescale 1ns/1ps
module tb_syl_fetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_kind;
  logic [5:0]  out_syl;
  logic [31:0] out_imm;
  logic [31:0] pc_o;
  logic [2:0]  sc_o;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_target = '0;
  logic        halted;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  syl_fetch_seq dut (
    .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_syl(out_syl), .out_imm(out_imm), .pc_o(pc_o),
    .sc_o(sc_o), .redir_valid(redir_valid), .redir_target(redir_target),
    .halted(halted)
  );

  // One-cycle synchronous instruction memory, 256 words
  logic [31:0] mem [0:255];
  always @(posedge clk) if (imem_req) imem_rdata <= mem[imem_addr[9:2]];

  function automatic logic [31:0] pack5(input int a, input int b, input int c,
                                        input int d, input int e);
    return (a << 24) | (b << 18) | (c << 12) | (d << 6) | e;
  endfunction

  // Accepted-item log
  int          mode = 0;       // 0 never, 1 always, 2 alternate, 3 pseudo-random
  logic [7:0]  lfsr = 8'h5b;
  int          tick = 0;
  int          n_log = 0;
  logic        log_kind [0:127];
  logic [31:0] log_val  [0:127];
  logic [31:0] log_pc   [0:127];
  logic [2:0]  log_sc   [0:127];

  always @(negedge clk) begin
    tick++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (mode)
      1: out_ready = 1'b1;
      2: out_ready = tick[0];
      3: out_ready = lfsr[0] | lfsr[2];
      default: out_ready = 1'b0;
    endcase
    if (!rst_n) n_log = 0;
    else if (out_valid && out_ready && !redir_valid && n_log < 128) begin
      log_kind[n_log] = out_kind;
      log_val[n_log]  = out_kind ? out_imm : {26'd0, out_syl};
      log_pc[n_log]   = pc_o;
      log_sc[n_log]   = sc_o;
      n_log++;
    end
  end

  // Expected stream from walking memory
  int          n_exp;
  logic        exp_kind [0:127];
  logic [31:0] exp_val  [0:127];
  logic [31:0] exp_pc   [0:127];
  logic [2:0]  exp_sc   [0:127];

  task automatic build_exp(input logic [31:0] start);
    logic [31:0] a;
    logic [31:0] w;
    int s;
    bit stop;
    a = start; n_exp = 0; stop = 0;
    while (!stop && n_exp < 120) begin
      w = mem[a[9:2]];
      a = a + 32'd4;
      if (w[31]) begin
        exp_kind[n_exp] = 1'b1; exp_val[n_exp] = w * 2;
        exp_pc[n_exp] = a; exp_sc[n_exp] = 3'd0; n_exp++;
      end else if (w[31:30] == 2'b00) begin
        for (int k = 0; k < 5; k++) begin
          s = (w / (1 << (6 * (4 - k)))) % 64;
          exp_kind[n_exp] = 1'b0; exp_val[n_exp] = s;
          exp_pc[n_exp] = a; exp_sc[n_exp] = 3'((k + 1) % 5); n_exp++;
          if (s == 0) begin stop = 1; break; end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
    end
  endtask

  task automatic compare_log(input string tag);
    check(n_log == n_exp, "R5", {tag, " item count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      check(log_kind[i] == exp_kind[i] && log_val[i] == exp_val[i],
            exp_kind[i] ? "R3" : "R5", {tag, " item value"}, log_val[i], exp_val[i]);
      check(log_pc[i] == exp_pc[i], "R11", {tag, " item pc"}, log_pc[i], exp_pc[i]);
      check(log_sc[i] == exp_sc[i], "R6", {tag, " item sc"}, 32'(log_sc[i]), 32'(exp_sc[i]));
    end
  endtask

  task automatic do_reset(input int m);
    rst_n = 1'b0;
    mode = m;
    repeat (3) @(negedge clk);
    check(!halted && !out_valid, "R1", "idle in reset", {30'd0, halted, out_valid}, 0);
    rst_n = 1'b1;
    #0.5;
    check(imem_req && imem_addr == 32'h0, "R1", "first fetch address", imem_addr, 0);
  endtask

  task automatic halt_checks(input string tag);
    check(halted == 1'b1, "R9", {tag, " halted"}, 32'(halted), 1);
    redir_valid = 1'b1; redir_target = 32'h200;
    @(negedge clk);
    redir_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(halted && !imem_req && !out_valid, "R9", {tag, " quiet after halt"},
            {29'd0, halted, imem_req, out_valid}, 32'h4);
    end
  endtask

  initial begin
    // Sweep image: every nonzero code in order, pad with no-ops
    for (int i = 0; i < 256; i++) mem[i] = pack5(1, 1, 1, 1, 1);
    for (int w = 0; w < 13; w++) begin
      int c[5];
      for (int k = 0; k < 5; k++) c[k] = (1 + 5 * w + k > 63) ? 1 : 1 + 5 * w + k;
      mem[w] = pack5(c[0], c[1], c[2], c[3], c[4]);
    end
    mem[13] = 32'hC0404040;           // wide immediate
    mem[14] = 32'h5A5A5A5A;           // reserved
    mem[15] = 32'hFFFFFFFF;           // wide immediate, all ones
    mem[16] = pack5(5, 0, 9, 9, 9);   // halt in slot 1
    mem[128] = pack5(7, 8, 9, 10, 11);
    mem[129] = pack5(12, 0, 1, 1, 1);

    // Sweeps over three ready patterns
    for (int m = 1; m <= 3; m++) begin
      do_reset(m);
      build_exp(32'h0);
      while (!halted) @(negedge clk);
      compare_log($sformatf("sweep mode %0d", m));
      halt_checks($sformatf("sweep mode %0d", m));
    end

    // Directed items from the sweep stream
    check(exp_val[65] == 32'h80808080 && log_val[65] == 32'h80808080, "R3",
          "0xC0404040 push value", log_val[65], 32'h80808080);
    check(log_val[66] == 32'hFFFFFFFE && log_pc[66] == 32'h40, "R4",
          "reserved word skipped", log_pc[66], 32'h40);
    check(log_val[0] == 32'd1 && log_kind[0] == 1'b0, "R10", "no-op passes as item",
          log_val[0], 1);

    // Stall, redirect mid-word, then run to halt
    do_reset(0);
    while (!out_valid) @(negedge clk);
    check(out_syl == 6'd1 && pc_o == 32'h4 && sc_o == 3'd1, "R6",
          "first slot pc/sc", pc_o, 32'h4);
    repeat (3) begin
      @(negedge clk);
      check(out_valid && out_syl == 6'd1 && sc_o == 3'd1, "R7", "stalled item holds",
            {26'd0, out_syl}, 1);
    end
    redir_valid = 1'b1; redir_target = 32'h201; mode = 1;
    @(negedge clk);
    redir_valid = 1'b0;
    check(imem_req && imem_addr == 32'h200 && !out_valid && sc_o == 3'd0, "R8",
          "redirect refetch address", imem_addr, 32'h200);
    @(negedge clk);
    check(!out_valid, "R2", "no item during capture", 32'(out_valid), 0);
    build_exp(32'h200);
    while (!halted) @(negedge clk);
    compare_log("redirect");
    check(n_log > 2 && log_val[0] == 32'd7, "R8", "rest of old word discarded",
          log_val[0], 7);
    check(n_log > 2 && log_val[2] == 32'd9 && log_pc[2] == 32'h204 && log_sc[2] == 3'd3,
          "R6", "middle slot at 0x200", log_pc[2], 32'h204);
    halt_checks("redirect");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule